// File: doc/BRIEF.md
# Dual-Bank Configuration Image Validator

This block checks two 8 KiB configuration-store images and decides which one holds the live settings. Both images arrive over one shared byte stream. Each byte carries a bank tag and its byte index, and bytes of the two banks may be interleaved freely. For every bank the block runs three integrity checks in parallel with the stream: a fixed marker byte at offset 0, an 8-bit end-around-carry checksum over the 16-byte header, and a modulo-65521 dual-sum (Adler-style) checksum over everything from offset 0x14 to the end of the bank.

A bank that passes all three checks reports its 32-bit generation number. A bank that fails any check reports zero. Once both banks have delivered their final byte, the block compares the two reported generations and names the active bank. The higher generation wins, and bank 0 wins every tie. A start pulse clears all state before a new pair of images is fed in. Within each bank the bytes are expected in ascending index order, each index exactly once.

Top module: `nvb_select`

## Requirements
- R1: After reset, `done_o` and `active_o` are 0, `gen_o` is 0, `bank_ok_o` is 00 and `bank_gen_o` is 0.
- R2: A bank whose byte 0 is not 0x5A is reported invalid.
- R3: The header checksum starts from byte 0 and then adds bytes 2 to 15 in a 16-bit sum. The sum is reduced by repeatedly replacing it with (low byte + high byte) until it fits in 8 bits. A bank whose byte 1 differs from this result is invalid.
- R4: The body checksum starts with low = 1 and high = 0. For each byte at index 0x14 through 8191 it adds the byte to low and then adds low to high, both modulo 65521. The value {high, low} must equal the big-endian word at bytes 0x10..0x13 (byte 0x10 is the most significant), or the bank is invalid.
- R5: `bank_gen_o[32*b +: 32]` is the big-endian word at bytes 0x14..0x17 of bank b when that bank passes R2–R4, and 0 otherwise. `bank_ok_o[b]` is 1 exactly when the bank passes.
- R6: `active_o` is 1 only when bank 1's reported generation is strictly greater than bank 0's. `gen_o` is the reported generation of the active bank.
- R7: `done_o` pulses for one cycle two cycles after the edge that accepts the later of the two banks' byte 8191. The results hold until the next start.
- R8: A `start_i` pulse clears all results and accumulators, so a scan depends only on the bytes accepted after it.
- R9: A byte is taken only in cycles with `byte_vld_i` high, and only by the bank named by `bank_i` (0 or 1). Bytes in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears state before a new scan |
| byte_vld_i | input | 1 | Stream byte valid |
| bank_i | input | 1 | Bank the byte belongs to |
| byte_idx_i | input | 13 | Byte offset within the bank |
| byte_i | input | 8 | Byte value |
| done_o | output | 1 | One-cycle pulse when both banks are judged |
| active_o | output | 1 | Selected bank |
| gen_o | output | 32 | Generation of the selected bank |
| bank_ok_o | output | 2 | Per-bank validity |
| bank_gen_o | output | 64 | Per-bank reported generation, bank 1 in the upper half |

## Verification
Any corruption in an accumulator (header sum, Adler low/high) or in a captured field remains hidden until the final byte of that bank. At that point it shows up as a flipped `bank_ok_o` bit, or as a zeroed or wrong entry in `bank_gen_o`, and that can move `active_o`. All of these appear at the single `done_o` pulse two cycles after the last byte. The scans therefore target each check in isolation: a bad marker, a bad header sum, a bad body sum, and generation ties. In every scan the stream also carries idle cycles with misleading data, so a wrongly taken byte changes a verdict.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    localparam int unsigned BANK_BYTES_DEF = 8192;
    localparam logic [7:0]  MARK_BYTE      = 8'h5A;
    localparam logic [16:0] ADL_MOD        = 17'd65521;
    localparam int unsigned CK_POS         = 1;
    localparam int unsigned HDR_LAST       = 15;
    localparam int unsigned ADL_POS        = 16;
    localparam int unsigned GEN_POS        = 20;
    localparam int unsigned BODY_START     = 20;

    typedef struct packed {
        logic        ok;
        logic [31:0] gen;
    } bank_res_t;

    // two end-around folds always bring a 16-bit sum into 8 bits
    function automatic logic [7:0] fold8(input logic [15:0] s);
        logic [8:0] t1;
        logic [8:0] t2;
        t1 = {1'b0, s[7:0]} + {1'b0, s[15:8]};
        t2 = {1'b0, t1[7:0]} + {8'd0, t1[8]};
        return t2[7:0];
    endfunction

    // both operands below the modulus, so one conditional subtract suffices
    function automatic logic [15:0] mod_add(input logic [16:0] a, input logic [16:0] b);
        logic [16:0] s;
        s = a + b;
        if (s >= ADL_MOD) s = s - ADL_MOD;
        return s[15:0];
    endfunction

endpackage

// File: rtl/nvb_hdr_sum.sv
module nvb_hdr_sum (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  byte_i,
    output logic [15:0] sum_o
);
    always_ff @(posedge clk) begin
        if (rst || clr)  sum_o <= '0;
        else if (en)     sum_o <= sum_o + {8'd0, byte_i};
    end
endmodule

// File: rtl/nvb_adler.sv
module nvb_adler
    import nvb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  byte_i,
    output logic [15:0] lo_o,
    output logic [15:0] hi_o
);
    logic [15:0] lo_nx;

    assign lo_nx = mod_add({1'b0, lo_o}, {9'd0, byte_i});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_o <= 16'd1;
            hi_o <= 16'd0;
        end else if (en) begin
            lo_o <= lo_nx;
            hi_o <= mod_add({1'b0, hi_o}, {1'b0, lo_nx});
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, lo_o} < ADL_MOD) && ({1'b0, hi_o} < ADL_MOD));
endmodule

// File: rtl/nvb_bank_check.sv
module nvb_bank_check
    import nvb_pkg::*;
#(
    parameter int unsigned BANK_BYTES = BANK_BYTES_DEF,
    localparam int unsigned IDX_W = $clog2(BANK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             take_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       byte_i,
    output logic             done_o,
    output bank_res_t        res_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

    logic        mark_ok;
    logic [7:0]  ck_st;
    logic [31:0] adl_st;
    logic [31:0] gen_st;
    logic        fin;
    logic        hdr_en, adl_en;
    logic [15:0] hsum, lo, hi;
    logic        all_ok;

    assign hdr_en = take_i && ((idx_i == '0) ||
                    (idx_i > IDX_W'(CK_POS) && idx_i <= IDX_W'(HDR_LAST)));
    assign adl_en = take_i && (idx_i >= IDX_W'(BODY_START));

    nvb_hdr_sum u_hdr (
        .clk(clk), .rst(rst), .clr(start_i), .en(hdr_en && !start_i),
        .byte_i(byte_i), .sum_o(hsum)
    );

    nvb_adler u_adl (
        .clk(clk), .rst(rst), .clr(start_i), .en(adl_en && !start_i),
        .byte_i(byte_i), .lo_o(lo), .hi_o(hi)
    );

    assign all_ok = mark_ok && (fold8(hsum) == ck_st) && ({hi, lo} == adl_st);

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            mark_ok <= 1'b0;
            ck_st   <= '0;
            adl_st  <= '0;
            gen_st  <= '0;
            fin     <= 1'b0;
            done_o  <= 1'b0;
            res_o   <= '0;
        end else begin
            fin    <= take_i && (idx_i == LAST_IDX);
            done_o <= fin;
            if (take_i) begin
                if (idx_i == '0)
                    mark_ok <= (byte_i == MARK_BYTE);
                if (idx_i == IDX_W'(CK_POS))
                    ck_st <= byte_i;
                if (idx_i >= IDX_W'(ADL_POS) && idx_i < IDX_W'(ADL_POS + 4))
                    adl_st <= {adl_st[23:0], byte_i};
                if (idx_i >= IDX_W'(GEN_POS) && idx_i < IDX_W'(GEN_POS + 4))
                    gen_st <= {gen_st[23:0], byte_i};
            end
            if (fin) begin
                res_o.ok  <= all_ok;
                res_o.gen <= all_ok ? gen_st : 32'd0;
            end
        end
    end

    // R5
    gen_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && res_o.ok) |-> (res_o.gen == gen_st));

    // R5
    bad_gen_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res_o.ok |-> (res_o.gen == 32'd0));
endmodule

// File: rtl/nvb_pick.sv
module nvb_pick
    import nvb_pkg::*;
(
    input  bank_res_t   b0_i,
    input  bank_res_t   b1_i,
    output logic        sel_o,
    output logic [31:0] gen_o
);
    assign sel_o = b1_i.gen > b0_i.gen;
    assign gen_o = sel_o ? b1_i.gen : b0_i.gen;
endmodule

// File: rtl/nvb_select.sv
module nvb_select
    import nvb_pkg::*;
#(
    parameter int unsigned BANK_BYTES = BANK_BYTES_DEF,
    localparam int unsigned IDX_W = $clog2(BANK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             byte_vld_i,
    input  logic             bank_i,
    input  logic [IDX_W-1:0] byte_idx_i,
    input  logic [7:0]       byte_i,
    output logic             done_o,
    output logic             active_o,
    output logic [31:0]      gen_o,
    output logic [1:0]       bank_ok_o,
    output logic [63:0]      bank_gen_o
);
    localparam int unsigned NBANK = 2;

    bank_res_t        res [NBANK];
    logic [NBANK-1:0] bdone;
    logic [NBANK-1:0] seen, seen_nx;
    logic             pick_sel;
    logic [31:0]      pick_gen;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        nvb_bank_check #(.BANK_BYTES(BANK_BYTES)) u_chk (
            .clk(clk), .rst(rst), .start_i(start_i),
            .take_i(byte_vld_i && (bank_i == 1'(b))),
            .idx_i(byte_idx_i), .byte_i(byte_i),
            .done_o(bdone[b]), .res_o(res[b])
        );
        assign bank_ok_o[b]          = res[b].ok;
        assign bank_gen_o[32*b +: 32] = res[b].gen;
    end

    nvb_pick u_pick (
        .b0_i(res[0]), .b1_i(res[1]), .sel_o(pick_sel), .gen_o(pick_gen)
    );

    assign seen_nx = seen | bdone;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            seen     <= '0;
            done_o   <= 1'b0;
            active_o <= 1'b0;
            gen_o    <= '0;
        end else begin
            seen   <= seen_nx;
            done_o <= (&seen_nx) && !(&seen);
            if ((&seen_nx) && !(&seen)) begin
                active_o <= pick_sel;
                gen_o    <= pick_gen;
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    tie_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && (bank_gen_o[63:32] <= bank_gen_o[31:0])) |-> !active_o);

    // R6
    newer_wins_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (gen_o == (active_o ? bank_gen_o[63:32] : bank_gen_o[31:0])));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(gen_o) && $stable(active_o)));
endmodule

// File: tb/nvb_select_test.sv
module nvb_select_test;
    localparam int NB = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic        bank_i = 1'b0;
    logic [12:0] byte_idx_i = '0;
    logic [7:0]  byte_i = '0;
    logic        done_o, active_o;
    logic [31:0] gen_o;
    logic [1:0]  bank_ok_o;
    logic [63:0] bank_gen_o;

    int checks = 0;
    int fails  = 0;

    int          seed [2];
    logic [31:0] gen  [2];
    logic [7:0]  mark [2];
    logic [7:0]  ckv  [2];
    logic [31:0] adlv [2];

    always #2 clk = ~clk;

    nvb_select uut (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .bank_i(bank_i), .byte_idx_i(byte_idx_i), .byte_i(byte_i),
        .done_o(done_o), .active_o(active_o), .gen_o(gen_o),
        .bank_ok_o(bank_ok_o), .bank_gen_o(bank_gen_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] raw(input int s, input int i);
        return 8'((i * s) + (i >> 5) + s * 3);
    endfunction

    function automatic logic [7:0] img(input int b, input int i);
        if (i == 0)  return mark[b];
        if (i == 1)  return ckv[b];
        if (i <= 15) return 8'hE0 | raw(seed[b], i);
        if (i <= 19) return 8'(adlv[b] >> (8 * (19 - i)));
        if (i <= 23) return 8'(gen[b] >> (8 * (23 - i)));
        return raw(seed[b], i);
    endfunction

    task automatic prep(input int b, input int s, input logic [31:0] g,
                        input logic [7:0] mk, input logic [7:0] ckflip,
                        input logic [31:0] adlflip);
        int sum, lo, hi;
        seed[b] = s; gen[b] = g; mark[b] = mk;
        sum = mk;
        for (int i = 2; i <= 15; i++) sum += img(b, i);
        while (sum > 255) sum = (sum & 255) + (sum >> 8);
        ckv[b] = 8'(sum) ^ ckflip;
        lo = 1; hi = 0;
        for (int i = 20; i < NB; i++) begin
            lo = (lo + img(b, i)) % 65521;
            hi = (hi + lo) % 65521;
        end
        adlv[b] = {hi[15:0], lo[15:0]} ^ adlflip;
    endtask

    task automatic scan(input string tag, input logic [1:0] eok);
        logic [31:0] eg0, eg1, egen;
        logic        eact;
        int          k;
        eg0  = eok[0] ? gen[0] : 32'd0;
        eg1  = eok[1] ? gen[1] : 32'd0;
        eact = eg1 > eg0;
        egen = eact ? eg1 : eg0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk({tag, " R8 ok cleared by start"}, {62'd0, bank_ok_o}, 64'd0);
        chk({tag, " R8 done low after start"}, {63'd0, done_o}, 64'd0);
        for (int i = 0; i < NB; i++) begin
            for (int b = 0; b < 2; b++) begin
                if (b == 0 && (i % 13) == 5) begin
                    // R9: junk that would break the marker if taken
                    @(negedge clk);
                    byte_vld_i = 1'b0; bank_i = 1'b0; byte_idx_i = '0; byte_i = 8'h00;
                end
                @(negedge clk);
                byte_vld_i = 1'b1; bank_i = 1'(b); byte_idx_i = 13'(i); byte_i = img(b, i);
            end
        end
        @(negedge clk); byte_vld_i = 1'b0;
        // last byte taken at the edge before this negedge; done two edges later
        k = 0;
        while (!done_o && k < 10) begin @(negedge clk); k++; end
        chk({tag, " R7 done latency"}, 64'(k), 64'd2);
        chk({tag, " ok bits R9"}, {62'd0, bank_ok_o}, {62'd0, eok});
        chk({tag, " R5 bank0 gen"}, {32'd0, bank_gen_o[31:0]}, {32'd0, eg0});
        chk({tag, " R5 bank1 gen"}, {32'd0, bank_gen_o[63:32]}, {32'd0, eg1});
        chk({tag, " R6 active"}, {63'd0, active_o}, {63'd0, eact});
        chk({tag, " R6 gen_o"}, {32'd0, gen_o}, {32'd0, egen});
        @(negedge clk);
        chk({tag, " R7 single pulse"}, {63'd0, done_o}, 64'd0);
        chk({tag, " R7 hold"}, {32'd0, gen_o}, {32'd0, egen});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", {63'd0, done_o}, 64'd0);
        chk("R1 active", {63'd0, active_o}, 64'd0);
        chk("R1 gen", {32'd0, gen_o}, 64'd0);
        chk("R1 ok", {62'd0, bank_ok_o}, 64'd0);
        chk("R1 bank gens", bank_gen_o, 64'd0);

        prep(0, 7, 32'd5, 8'h5A, 8'h00, 32'd0);
        prep(1, 11, 32'd9, 8'h5A, 8'h00, 32'd0);
        scan("both valid newer1 R4", 2'b11);

        prep(0, 3, 32'd7, 8'h5A, 8'h00, 32'd0);
        prep(1, 19, 32'd7, 8'h5A, 8'h00, 32'd0);
        scan("tie R6", 2'b11);

        prep(0, 5, 32'd40, 8'h33, 8'h00, 32'd0);
        prep(1, 23, 32'd3, 8'h5A, 8'h00, 32'd0);
        scan("bad marker R2", 2'b10);

        prep(0, 9, 32'd2, 8'h5A, 8'h00, 32'd0);
        prep(1, 29, 32'h0100_0000, 8'h5A, 8'h01, 32'd0);
        scan("bad header sum R3", 2'b01);

        prep(0, 13, 32'hFFFF_FFFF, 8'h5A, 8'h00, 32'h0000_0100);
        prep(1, 31, 32'd1, 8'h5A, 8'h00, 32'd0);
        scan("bad body sum R4", 2'b10);

        prep(0, 17, 32'd8, 8'h00, 8'h00, 32'd0);
        prep(1, 37, 32'd6, 8'h5A, 8'h00, 32'h8000_0000);
        scan("both invalid R5", 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule